// File: doc/BRIEF.md
# Dual-Channel Input Capture Timer

A 16-bit free-running up-counter with two timestamp channels. The counter advances by one on every cycle in which the prescaled count enable is high and the run bit is set. It is never cleared by a match: it rolls from FFFFh to 0000h and sets an overflow flag when it does. Each channel watches one external pin through a two-flop synchronizer. When the pin shows the edge chosen for that channel (rising, falling or either), the current counter value is stored in the channel's capture register and the channel's capture flag is set.

Each capture register has a partner history register. When history is enabled for a channel, each new capture pushes the value it replaces into the history register in the same clock cycle. Firmware can then read two consecutive timestamps and work out a pulse width (either-edge mode) or a period (single-edge mode). A small register port gives access to control, status, counter, capture and history values. A single interrupt output is the OR of each flag gated by its enable.

Top module: `dual_capture_timer`

## Requirements
- R1: After an asynchronous active-low reset, every register reads 0, all three flag outputs are low and `irq_o` is low.
- R2: The counter (address 2) increments by one at each clock edge where control bit 0 (run) and `tick_i` are both 1. Otherwise it holds its value. A register write to address 2 loads the counter and takes priority over counting.
- R3: A count step from FFFFh wraps the counter to 0000h and sets the overflow flag (status bit 2, `flag_ovf_o`).
- R4: The capture edge for channel A is set by control bits 4:3, and for channel B by bits 6:5. The codes are 00 rising, 01 falling, and 10 or 11 either edge. An edge that is not selected changes neither the capture register nor the flag.
- R5: An accepted edge stores the counter value in the channel's capture register (A at address 3, B at address 4) and sets its flag (status bit 0 for A, bit 1 for B). This happens at the third rising clock edge, counting the edge that first samples the new pin level.
- R6: When control bit 1 (channel A) or bit 2 (channel B) is set, a capture moves the old capture value into the history register (A at address 5, B at address 6) in the same cycle. When the bit is clear, the history register keeps its value.
- R7: While run is 0, pin edges cause no capture and set no flag. They are not remembered later.
- R8: A status flag is cleared only by a write of 0 to its bit at address 1, and only if a read of address 1 that returned 1 for that bit came before it. Any status write disarms all bits. Writing 1 leaves the flag alone. A hardware set in the same cycle as a clear wins.
- R9: `irq_o` is high when any flag is set and its enable is set. The enables are control bit 7 for A, bit 8 for B and bit 9 for overflow.
- R10: If a capture and a register write to the same capture or history register fall in one cycle, the capture result is kept.
- R11: Register writes to addresses 0 and 2 to 6 update the addressed register, and reads return it zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Prescaled count enable |
| cap_a_i | input | 1 | Channel A capture pin (asynchronous) |
| cap_b_i | input | 1 | Channel B capture pin (asynchronous) |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe (arms status clear) |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data, combinational from address |
| flag_cap_a_o | output | 1 | Channel A capture flag |
| flag_cap_b_o | output | 1 | Channel B capture flag |
| flag_ovf_o | output | 1 | Counter overflow flag |
| irq_o | output | 1 | Combined interrupt |

## Verification
The bench targets edge selection with the pin moving in the direction that was not chosen. A wrong decoder would capture there and corrupt the timestamp pair. It lines up a register write with the capture clock on the same channel. A design that gives the write priority would leave DEADh in place of the counter value. It also steps the counter across FFFFh, where a wrong wrap compare would miss the overflow flag or stall. Finally, it tries to clear status without a read first, and with a write of 1. A design without arming would drop the flag early, and `irq_o` would fall with it.

// File: rtl/dct_pkg.sv
`timescale 1ns/1ps
package dct_pkg;
  localparam int ADDR_W  = 3;
  localparam int NUM_CH  = 2;
  localparam int ST_W    = NUM_CH + 1;   // capture flags then overflow
  localparam int CTRL_W  = 10;

  // control field positions
  localparam int RUN_BIT  = 0;
  localparam int BUF_LSB  = 1;
  localparam int EDGE_LSB = 3;
  localparam int IE_LSB   = 7;

  localparam logic [ADDR_W-1:0] ADR_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_STAT = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_CNT  = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_CAPA = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_CAPB = 3'd4;
  localparam logic [ADDR_W-1:0] ADR_BUFA = 3'd5;
  localparam logic [ADDR_W-1:0] ADR_BUFB = 3'd6;

  localparam int CAP_BASE = 3;
  localparam int BUF_BASE = 5;

  typedef enum logic [1:0] {
    EDGE_RISE = 2'b00,
    EDGE_FALL = 2'b01,
    EDGE_ANY  = 2'b10
  } edge_e;
endpackage

// File: rtl/dct_sync_edge.sv
`timescale 1ns/1ps
module dct_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pin_i,
  input  logic [1:0] edge_sel_i,
  input  logic       arm_i,
  output logic       hit_o
);
  import dct_pkg::*;

  logic [STAGES-1:0] sync_q;
  logic              prev_q;
  logic              cur, rise, fall, sel;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign cur  = sync_q[STAGES-1];
  assign rise = cur & ~prev_q;
  assign fall = ~cur & prev_q;

  always_comb begin
    case (edge_sel_i)
      EDGE_RISE: sel = rise;
      EDGE_FALL: sel = fall;
      default:   sel = rise | fall;
    endcase
  end

  // edges seen while stopped are consumed, not deferred
  assign hit_o = arm_i & sel;
endmodule

// File: rtl/dct_counter.sv
`timescale 1ns/1ps
module dct_counter #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic         tick_i,
  input  logic         ld_i,
  input  logic [W-1:0] ld_val_i,
  output logic [W-1:0] count_o,
  output logic         wrap_o
);
  localparam logic [W-1:0] MAX_VAL = {W{1'b1}};

  logic [W-1:0] cnt_q;
  logic         step;

  assign step   = run_i & tick_i & ~ld_i;
  assign wrap_o = step & (cnt_q == MAX_VAL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_q <= '0;
    else if (ld_i) cnt_q <= ld_val_i;
    else if (step) cnt_q <= cnt_q + W'(1);
  end

  assign count_o = cnt_q;
endmodule

// File: rtl/dct_capture_chan.sv
`timescale 1ns/1ps
module dct_capture_chan #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         hit_i,
  input  logic         buf_en_i,
  input  logic [W-1:0] count_i,
  input  logic         cap_we_i,
  input  logic         buf_we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] cap_o,
  output logic [W-1:0] buf_o
);
  logic [W-1:0] cap_q, buf_q;

  // capture has priority over register writes
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cap_q <= '0;
    else if (hit_i)    cap_q <= count_i;
    else if (cap_we_i) cap_q <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 buf_q <= '0;
    else if (hit_i && buf_en_i)  buf_q <= cap_q;
    else if (buf_we_i && !hit_i) buf_q <= wdata_i;
  end

  assign cap_o = cap_q;
  assign buf_o = buf_q;
endmodule

// File: rtl/dct_status.sv
`timescale 1ns/1ps
module dct_status #(
  parameter int N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic         rd_i,
  input  logic         wr_i,
  input  logic [N-1:0] wdata_i,
  output logic [N-1:0] flags_o
);
  logic [N-1:0] flag_q, arm_q, clr;

  assign clr = wr_i ? (arm_q & ~wdata_i) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= '0;
      arm_q  <= '0;
    end else begin
      flag_q <= (flag_q & ~clr) | set_i;
      if (wr_i)      arm_q <= '0;
      else if (rd_i) arm_q <= flag_q;
    end
  end

  assign flags_o = flag_q;
endmodule

// File: rtl/dual_capture_timer.sv
`timescale 1ns/1ps
module dual_capture_timer
  import dct_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              cap_a_i,
  input  logic              cap_b_i,
  input  logic              reg_we_i,
  input  logic              reg_re_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [CNT_W-1:0]  reg_wdata_i,
  output logic [CNT_W-1:0]  reg_rdata_o,
  output logic              flag_cap_a_o,
  output logic              flag_cap_b_o,
  output logic              flag_ovf_o,
  output logic              irq_o
);
  logic [CTRL_W-1:0] ctrl_q;
  logic [CNT_W-1:0]  count_q;
  logic              wrap;
  logic [NUM_CH-1:0] pins, hit;
  logic [CNT_W-1:0]  cap_q [NUM_CH];
  logic [CNT_W-1:0]  buf_q [NUM_CH];
  logic [ST_W-1:0]   flags, ie;
  logic              run;

  assign run  = ctrl_q[RUN_BIT];
  assign pins = {cap_b_i, cap_a_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= '0;
    else if (reg_we_i && reg_addr_i == ADR_CTRL) ctrl_q <= reg_wdata_i[CTRL_W-1:0];
  end

  dct_counter #(.W(CNT_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (run),
    .tick_i   (tick_i),
    .ld_i     (reg_we_i && reg_addr_i == ADR_CNT),
    .ld_val_i (reg_wdata_i),
    .count_o  (count_q),
    .wrap_o   (wrap)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    localparam logic [ADDR_W-1:0] CAP_ADR = ADDR_W'(CAP_BASE + ch);
    localparam logic [ADDR_W-1:0] BUF_ADR = ADDR_W'(BUF_BASE + ch);

    dct_sync_edge #(.STAGES(SYNC_STAGES)) u_edge (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .pin_i      (pins[ch]),
      .edge_sel_i (ctrl_q[EDGE_LSB+2*ch +: 2]),
      .arm_i      (run),
      .hit_o      (hit[ch])
    );

    dct_capture_chan #(.W(CNT_W)) u_chan (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .hit_i    (hit[ch]),
      .buf_en_i (ctrl_q[BUF_LSB+ch]),
      .count_i  (count_q),
      .cap_we_i (reg_we_i && reg_addr_i == CAP_ADR),
      .buf_we_i (reg_we_i && reg_addr_i == BUF_ADR),
      .wdata_i  (reg_wdata_i),
      .cap_o    (cap_q[ch]),
      .buf_o    (buf_q[ch])
    );
  end

  dct_status #(.N(ST_W)) u_stat (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   ({wrap, hit}),
    .rd_i    (reg_re_i && reg_addr_i == ADR_STAT),
    .wr_i    (reg_we_i && reg_addr_i == ADR_STAT),
    .wdata_i (reg_wdata_i[ST_W-1:0]),
    .flags_o (flags)
  );

  assign ie    = ctrl_q[IE_LSB +: ST_W];
  assign irq_o = |(flags & ie);

  assign flag_cap_a_o = flags[0];
  assign flag_cap_b_o = flags[1];
  assign flag_ovf_o   = flags[NUM_CH];

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      ADR_CTRL: reg_rdata_o[CTRL_W-1:0] = ctrl_q;
      ADR_STAT: reg_rdata_o[ST_W-1:0]   = flags;
      ADR_CNT:  reg_rdata_o = count_q;
      ADR_CAPA: reg_rdata_o = cap_q[0];
      ADR_CAPB: reg_rdata_o = cap_q[1];
      ADR_BUFA: reg_rdata_o = buf_q[0];
      ADR_BUFB: reg_rdata_o = buf_q[1];
      default:  reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/dct_checker.sv
`timescale 1ns/1ps
module dct_checker
  import dct_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic              reg_we_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic              run_i,
  input logic              buf_en_a_i,
  input logic              hit_a_i,
  input logic [CNT_W-1:0]  count_i,
  input logic [CNT_W-1:0]  cap_val_i,
  input logic [CNT_W-1:0]  buf_val_i,
  input logic              flag_ovf_i,
  input logic              flag_cap_a_i
);
  localparam logic [CNT_W-1:0] MAX_VAL = {CNT_W{1'b1}};

  logic cnt_wr, cap_wr, buf_wr;
  assign cnt_wr = reg_we_i && reg_addr_i == ADR_CNT;
  assign cap_wr = reg_we_i && reg_addr_i == ADR_CAPA;
  assign buf_wr = reg_we_i && reg_addr_i == ADR_BUFA;

  a_r2_count_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && tick_i && !cnt_wr) |=> count_i == CNT_W'($past(count_i) + CNT_W'(1)));

  a_r2_count_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(run_i && tick_i) && !cnt_wr) |=> $stable(count_i));

  a_r3_wrap_sets_ovf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && tick_i && !cnt_wr && count_i == MAX_VAL) |=> (flag_ovf_i && count_i == '0));

  a_r5_capture_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_a_i |=> flag_cap_a_i);

  a_r6_hist_gets_old: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_a_i && buf_en_a_i) |=> buf_val_i == $past(cap_val_i));

  a_r6_hist_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(hit_a_i && buf_en_a_i) && !buf_wr) |=> $stable(buf_val_i));

  a_r7_stopped_no_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !cap_wr) |=> $stable(cap_val_i));

  a_r10_capture_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_a_i |=> cap_val_i == $past(count_i));
endmodule

bind dual_capture_timer dct_checker #(.CNT_W(CNT_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .tick_i       (tick_i),
  .reg_we_i     (reg_we_i),
  .reg_addr_i   (reg_addr_i),
  .run_i        (ctrl_q[dct_pkg::RUN_BIT]),
  .buf_en_a_i   (ctrl_q[dct_pkg::BUF_LSB]),
  .hit_a_i      (hit[0]),
  .count_i      (count_q),
  .cap_val_i    (cap_q[0]),
  .buf_val_i    (buf_q[0]),
  .flag_ovf_i   (flag_ovf_o),
  .flag_cap_a_i (flag_cap_a_o)
);

// File: tb/dual_capture_timer_tb_top.sv
`timescale 1ns/1ps
module dual_capture_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        pin_a = 1'b0, pin_b = 1'b0;
  logic        we = 1'b0, re = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        f_a, f_b, f_o, irq;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  dual_capture_timer dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .cap_a_i(pin_a), .cap_b_i(pin_b),
    .reg_we_i(we), .reg_re_i(re), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .flag_cap_a_o(f_a), .flag_cap_b_o(f_b),
    .flag_ovf_o(f_o), .irq_o(irq)
  );

  typedef struct packed {
    logic [15:0] ctrl;
    logic [15:0] cnt;
    logic        pin;
    logic [15:0] cap;
    logic [15:0] hist;
    logic        flag;
  } vec_t;

  // channel A walk: ctrl, counter preset, new pin level, expected capture/history/flag
  localparam vec_t VECS [0:8] = '{
    '{16'h0003, 16'h0100, 1'b1, 16'h0100, 16'h0000, 1'b1},  // rising, hist on
    '{16'h0003, 16'h0200, 1'b0, 16'h0100, 16'h0000, 1'b0},  // falling ignored
    '{16'h000B, 16'h0300, 1'b1, 16'h0100, 16'h0000, 1'b0},  // rising ignored
    '{16'h000B, 16'h0400, 1'b0, 16'h0400, 16'h0100, 1'b1},  // falling taken
    '{16'h0013, 16'h0500, 1'b1, 16'h0500, 16'h0400, 1'b1},  // either edge
    '{16'h0013, 16'h0600, 1'b0, 16'h0600, 16'h0500, 1'b1},
    '{16'h0011, 16'h0700, 1'b1, 16'h0700, 16'h0500, 1'b1},  // hist off
    '{16'h0012, 16'h0800, 1'b0, 16'h0700, 16'h0500, 1'b0},  // stopped
    '{16'h0003, 16'hFFFF, 1'b1, 16'hFFFF, 16'h0700, 1'b1}
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk); addr = a; re = 1'b1;
    #1 d = rdata;
    @(negedge clk); re = 1'b0;
  endtask

  task automatic clear_flags();
    logic [15:0] s;
    rd(3'd1, s);
    wr(3'd1, 16'h0000);
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (1000000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog (R1 to R11 incomplete): actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    wait_n(3);
    rst_n = 1'b1;
    wait_n(1);

    // R1 reset state
    for (int a = 0; a < 7; a++) begin
      rd(3'(a), d);
      chk($sformatf("R1 reset reg %0d", a), d, 16'h0000);
    end
    chk("R1 reset flags", {13'd0, f_o, f_b, f_a}, 16'h0000);
    chk("R1 reset irq", {15'd0, irq}, 16'h0000);

    // R4 R5 R6 R7 vector walk on channel A
    for (int i = 0; i < 9; i++) begin
      wr(3'd0, VECS[i].ctrl);
      wr(3'd2, VECS[i].cnt);
      @(negedge clk); pin_a = VECS[i].pin;
      wait_n(4);
      rd(3'd3, d); chk($sformatf("R4 R5 R7 vec %0d capture", i), d, VECS[i].cap);
      rd(3'd5, d); chk($sformatf("R6 vec %0d history", i), d, VECS[i].hist);
      chk($sformatf("R5 vec %0d flag", i), {15'd0, f_a}, {15'd0, VECS[i].flag});
      clear_flags();
    end

    // R5 R6 channel B with history, channel A untouched
    wr(3'd0, 16'h0005);
    wr(3'd2, 16'h2222);
    @(negedge clk); pin_b = 1'b1; wait_n(4);
    rd(3'd4, d); chk("R5 chB capture", d, 16'h2222);
    chk("R5 chB flag", {15'd0, f_b}, 16'h0001);
    chk("R5 chA flag idle", {15'd0, f_a}, 16'h0000);
    clear_flags();
    wr(3'd2, 16'h3333);
    @(negedge clk); pin_b = 1'b0; wait_n(4);
    @(negedge clk); pin_b = 1'b1; wait_n(4);
    rd(3'd4, d); chk("R6 chB capture", d, 16'h3333);
    rd(3'd6, d); chk("R6 chB history", d, 16'h2222);
    rd(3'd3, d); chk("R6 chA unchanged", d, 16'hFFFF);
    clear_flags();

    // R10 capture versus register write in the same cycle
    wr(3'd0, 16'h0003);
    wr(3'd2, 16'h1234);
    @(negedge clk); pin_a = 1'b0; wait_n(4);
    @(negedge clk); pin_a = 1'b1;
    @(negedge clk);
    @(negedge clk); we = 1'b1; addr = 3'd3; wdata = 16'hDEAD;
    @(negedge clk); we = 1'b0;
    rd(3'd3, d); chk("R10 capture beats write", d, 16'h1234);
    rd(3'd5, d); chk("R10 history gets old value", d, 16'hFFFF);
    clear_flags();

    // R11 plain register writes
    wr(3'd3, 16'hBEEF); rd(3'd3, d); chk("R11 capture A write", d, 16'hBEEF);
    wr(3'd6, 16'h5A5A); rd(3'd6, d); chk("R11 history B write", d, 16'h5A5A);
    wr(3'd0, 16'h0155); rd(3'd0, d); chk("R11 control readback", d, 16'h0155);

    // R2 counting
    wr(3'd0, 16'h0001);
    wr(3'd2, 16'h0010);
    @(negedge clk); tick = 1'b1; wait_n(5); tick = 1'b0;
    rd(3'd2, d); chk("R2 five ticks", d, 16'h0015);
    wait_n(3);
    rd(3'd2, d); chk("R2 hold without tick", d, 16'h0015);
    wr(3'd0, 16'h0000);
    @(negedge clk); tick = 1'b1; wait_n(3); tick = 1'b0;
    rd(3'd2, d); chk("R2 hold when stopped", d, 16'h0015);

    // R3 wrap and overflow flag
    wr(3'd0, 16'h0001);
    wr(3'd2, 16'hFFFE);
    @(negedge clk); tick = 1'b1; wait_n(2); tick = 1'b0;
    rd(3'd2, d); chk("R3 wrap to zero", d, 16'h0000);
    chk("R3 overflow flag", {15'd0, f_o}, 16'h0001);

    // R9 interrupt gating
    chk("R9 irq masked", {15'd0, irq}, 16'h0000);
    wr(3'd0, 16'h0201);
    chk("R9 irq overflow enabled", {15'd0, irq}, 16'h0001);

    // R8 read-then-write-zero clearing
    wr(3'd1, 16'h0000);
    chk("R8 no clear without read", {15'd0, f_o}, 16'h0001);
    rd(3'd1, d); chk("R8 status read", d, 16'h0004);
    wr(3'd1, 16'h0004);
    chk("R8 write one keeps flag", {15'd0, f_o}, 16'h0001);
    wr(3'd1, 16'h0000);
    chk("R8 disarmed after write", {15'd0, f_o}, 16'h0001);
    rd(3'd1, d);
    wr(3'd1, 16'h0000);
    chk("R8 cleared", {15'd0, f_o}, 16'h0000);
    chk("R9 irq drops", {15'd0, irq}, 16'h0000);

    // R9 channel B enable, either edge
    wr(3'd0, 16'h0141);
    @(negedge clk); pin_b = 1'b0; wait_n(4);
    chk("R9 chB flag", {15'd0, f_b}, 16'h0001);
    chk("R9 irq from chB", {15'd0, irq}, 16'h0001);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule